// File: doc/BRIEF.md
# Transition-Minimizing Operand Bit Swapper

This block sits between two operand registers and a functional unit whose result does not change when the two operands trade bits at the same position. Examples are an adder or a bitwise AND, OR or XOR unit. For every bit position it decides whether to hand the unit the bits as given or exchanged. The aim is to toggle the unit's input wires as little as possible relative to the operands it was last given.

Each decision compares the new bits with the last applied bits, using exclusive-OR. A bit pair is exchanged only when the exchange turns two transitions into none. The applied operands are produced combinationally in the same cycle as the inputs. A pair of history registers keeps the applied values, and these registers advance only on cycles marked valid.

An optional wrapped adder shows that the exchange leaves the result unchanged. A parameter selects whether it is built.

Top module: `opswap_top`

## Requirements
- R1: `swap_mask` bit i is 1 exactly when op_a[i] differs from hist_a[i], op_b[i] differs from hist_b[i], and op_a[i] differs from op_b[i]. This is combinational, in the same cycle.
- R2: Where `swap_mask` bit i is 1, app_a[i] equals op_b[i] and app_b[i] equals op_a[i]. Where it is 0, the inputs pass through unchanged. This is combinational.
- R3: On a rising clock edge with `op_valid` high, `hist_a`/`hist_b` take the app_a/app_b values present before that edge.
- R4: On a rising clock edge with `op_valid` low, `hist_a`/`hist_b` keep their value, whatever the operand inputs do.
- R5: While `rst_n` is low, both history registers are zero. The first decisions after reset are therefore made against all-zero history.
- R6: With history 0x0003/0x000C and inputs 0x0004/0x000B, the applied operands are 0x0003/0x000C and `swap_mask` is 0x0007.
- R7: For each cycle, the number of bits where app differs from history, counted over both operands, is never more than the same count for the raw inputs.
- R8: With the adder built, `sum` (WIDTH+1 bits) equals op_a + op_b for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | The operands are real and the history may advance |
| op_a | input | WIDTH | First raw operand |
| op_b | input | WIDTH | Second raw operand |
| app_a | output | WIDTH | First operand as applied to the unit |
| app_b | output | WIDTH | Second operand as applied to the unit |
| swap_mask | output | WIDTH | 1 where the bit pair was exchanged |
| hist_a | output | WIDTH | Last applied first operand |
| hist_b | output | WIDTH | Last applied second operand |
| sum | output | WIDTH+1 | Wrapped adder result, or zero when the adder is not built |

## Verification
The applied operands, the mask and the sum are due in the same cycle as the inputs. The history is due one edge after a valid cycle. The bench therefore drives inputs at the falling edge and checks the combinational outputs a short settle time later. It checks the history just after the following rising edge, against its own copy of the history, which it advances only on valid cycles. Per-cycle and running toggle totals for the raw and the applied operands are compared in the same window.

// File: rtl/opswap_pkg.sv
package opswap_pkg;
    localparam int unsigned OPSWAP_DEF_W = 16;

    typedef enum logic {
        ADDER_NONE  = 1'b0,
        ADDER_BUILT = 1'b1
    } adder_sel_e;
endpackage

// File: rtl/opswap_decide.sv
module opswap_decide #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] new_a,
    input  logic [W-1:0] new_b,
    input  logic [W-1:0] prev_a,
    input  logic [W-1:0] prev_b,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic [W-1:0] swap
);
    // Per bit: exchanging removes two transitions only if both bits
    // moved and they disagree with each other.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic a_moved_d, b_moved_d, differ_d;
        always_comb begin
            a_moved_d = new_a[i] ^ prev_a[i];
            b_moved_d = new_b[i] ^ prev_b[i];
            differ_d  = new_a[i] ^ new_b[i];
            swap[i]   = a_moved_d & b_moved_d & differ_d;
            out_a[i]  = swap[i] ? new_b[i] : new_a[i];
            out_b[i]  = swap[i] ? new_a[i] : new_b[i];
        end
    end

    always_comb begin
        AST_BITS_KEPT: assert (((out_a ^ out_b) == (new_a ^ new_b)) &&
                               ((out_a & out_b) == (new_a & new_b))); // R2
    end
endmodule

// File: rtl/opswap_hist.sv
module opswap_hist #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.a = in_a;
            st_d.b = in_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a = st_q.a;
    assign out_b = st_q.b;

    AST_HIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (out_a == $past(in_a)) && (out_b == $past(in_b))); // R3
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(out_a) && $stable(out_b)); // R4
    always_comb begin
        if (!rst_n) AST_RESET_ZERO: assert (st_q == '0); // R5
    end
endmodule

// File: rtl/opswap_adder.sv
module opswap_adder #(
    parameter int unsigned          W    = 16,
    parameter opswap_pkg::adder_sel_e MODE = opswap_pkg::ADDER_BUILT
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   s
);
    if (MODE == opswap_pkg::ADDER_BUILT) begin : g_add
        always_comb s = {1'b0, x} + {1'b0, y};
    end else begin : g_none
        always_comb s = '0;
    end
endmodule

// File: rtl/opswap_top.sv
module opswap_top #(
    parameter int unsigned            WIDTH = opswap_pkg::OPSWAP_DEF_W,
    parameter opswap_pkg::adder_sel_e ADDER = opswap_pkg::ADDER_BUILT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] app_a,
    output logic [WIDTH-1:0] app_b,
    output logic [WIDTH-1:0] swap_mask,
    output logic [WIDTH-1:0] hist_a,
    output logic [WIDTH-1:0] hist_b,
    output logic [WIDTH:0]   sum
);
    localparam int unsigned CNT_W = $clog2(2 * WIDTH + 1);

    opswap_decide #(.W(WIDTH)) i_decide (
        .new_a (op_a),
        .new_b (op_b),
        .prev_a(hist_a),
        .prev_b(hist_b),
        .out_a (app_a),
        .out_b (app_b),
        .swap  (swap_mask)
    );

    opswap_hist #(.W(WIDTH)) i_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (op_valid),
        .in_a (app_a),
        .in_b (app_b),
        .out_a(hist_a),
        .out_b(hist_b)
    );

    opswap_adder #(.W(WIDTH), .MODE(ADDER)) i_adder (
        .x(app_a),
        .y(app_b),
        .s(sum)
    );

    logic [CNT_W-1:0] tog_raw, tog_app;
    always_comb begin
        tog_raw = CNT_W'($countones(op_a ^ hist_a)) + CNT_W'($countones(op_b ^ hist_b));
        tog_app = CNT_W'($countones(app_a ^ hist_a)) + CNT_W'($countones(app_b ^ hist_b));
    end

    AST_NO_MORE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        tog_app <= tog_raw); // R7
    AST_MASK_ONLY_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
        ((swap_mask & ~(op_a ^ hist_a)) == '0)); // R1

    if (ADDER == opswap_pkg::ADDER_BUILT) begin : g_sum_chk
        AST_SUM_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
            sum == ({1'b0, op_a} + {1'b0, op_b})); // R8
    end
endmodule

// File: tb/test_opswap_top.sv
module test_opswap_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [W-1:0] app_a, app_b, swap_mask, hist_a, hist_b;
    logic [W:0]   sum;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] m_ha = '0, m_hb = '0;
    longint tot_raw = 0, tot_app = 0;

    always #4 clk = ~clk;

    opswap_top #(.WIDTH(W)) i_opswap_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_a(op_a), .op_b(op_b), .app_a(app_a), .app_b(app_b),
        .swap_mask(swap_mask), .hist_a(hist_a), .hist_b(hist_b), .sum(sum)
    );

    function automatic logic [W-1:0] exp_mask(input logic [W-1:0] a, b, pa, pb);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++)
            m[i] = (a[i] != pa[i]) && (b[i] != pb[i]) && (a[i] != b[i]);
        return m;
    endfunction

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational outputs, then the history.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] m, ea, eb;
        int tr, ta;
        @(negedge clk);
        op_valid = v; op_a = a; op_b = b;
        #2;
        m  = exp_mask(a, b, m_ha, m_hb);
        ea = (a & ~m) | (b & m);
        eb = (b & ~m) | (a & m);
        chk("R1 mask", 64'(swap_mask), 64'(m));
        chk("R2 app_a", 64'(app_a), 64'(ea));
        chk("R2 app_b", 64'(app_b), 64'(eb));
        chk("R8 sum", 64'(sum), 64'({1'b0, a} + {1'b0, b}));
        tr = ones(a ^ m_ha) + ones(b ^ m_hb);
        ta = ones(ea ^ m_ha) + ones(eb ^ m_hb);
        chk("R7 toggles not higher", 64'(ta > tr), 64'(0));
        if (v) begin
            tot_raw += tr; tot_app += ta;
            m_ha = ea; m_hb = eb;
        end
        @(posedge clk);
        #1;
        chk(v ? "R3 hist_a" : "R4 hist_a hold", 64'(hist_a), 64'(m_ha));
        chk(v ? "R3 hist_b" : "R4 hist_b hold", 64'(hist_b), 64'(m_hb));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R5 reset hist_a", 64'(hist_a), 64'(0));
        chk("R5 reset hist_b", 64'(hist_b), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        // R5: first decisions against zero history; no swap on bits 0..3
        step(1'b1, 16'h0003, 16'h000C);
        // R6: documented vector
        step(1'b1, 16'h0004, 16'h000B);
        chk("R6 app_a", 64'(app_a), 64'(16'h0003));
        chk("R6 app_b", 64'(app_b), 64'(16'h000C));
        // both move to equal values: no exchange
        step(1'b1, 16'hFFFF, 16'hFFFF);
        // R4: invalid cycles with changing inputs leave history alone
        step(1'b0, 16'h1234, 16'h8765);
        step(1'b0, 16'h0000, 16'hFFFF);
        // full-width complement of history swaps every differing bit
        step(1'b1, 16'h00FF, 16'hFF00);
        step(1'b1, 16'hFF00, 16'h00FF);
        chk("R1 full swap mask", 64'(swap_mask), 64'(16'hFFFF));
        // adder carry-out
        step(1'b1, 16'hFFFF, 16'h0001);
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (k % 5 == 0) ? ~ra : W'($urandom);
            step(($urandom % 4) != 0, ra, rb);
        end
        chk("R7 total toggles not higher", 64'(tot_app > tot_raw), 64'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule